// File: doc/BRIEF.md
# Parallel Port Status-Flag Interface

This block sits between a simple processor bus and two byte-wide devices: a key-entry device that presents an 8-bit code and raises a Valid line, and a character printer that shows an Idle level when it can take another character and accepts one on a single-cycle strobe. The processor sees three register offsets above a base address. One offset holds the last captured input code, one takes the next output character, and one reports two ready flags. Each flag is set by a device handshake and cleared as a side effect of the processor touching the matching data register. Software polls the status register, reads or writes the data register, and never clears a flag on its own.

The input flag is a two-state machine. IN_EMPTY moves to IN_FULL on a synchronized rising edge of Valid. IN_FULL moves back to IN_EMPTY on a processor read of the input data register when no new edge arrives in that cycle. A fresh edge in IN_FULL reloads the data and keeps the state. The output side is a four-state machine. OUT_READY moves to OUT_BUSY if Idle drops. Any write to the output data register moves the machine to OUT_LOAD from every state. OUT_LOAD always moves to OUT_WAIT_ACK after one cycle. OUT_WAIT_ACK moves to OUT_BUSY once Idle is seen low. OUT_BUSY moves to OUT_READY once Idle is high again. Reset places the machine in OUT_BUSY, and in that state the output flag mirrors the Idle level.

Top module: `pario_flag_port`

## Requirements
- R1: While reset is held and just after it, the input data register and output character are 0, the input flag is 0, the strobe is low, and the output flag (status bit 1) equals the current level of the printer Idle line.
- R2: A rising edge of Valid passes through two synchronizing flip-flops and an edge detector, so the code is captured and the input flag rises on the third rising clock edge after Valid goes high, and not before.
- R3: Only a 0-to-1 change of Valid captures a code. Holding Valid high, or dropping it, neither sets the input flag again nor changes the input data register.
- R4: A processor read at offset 0 returns the input data register and clears the input flag (status bit 0) on that clock edge.
- R5: When a synchronized Valid edge and a read at offset 0 land on the same clock edge, the read returns the old code, the new code is stored, and the input flag stays 1.
- R6: A write at offset 1 loads the output character and clears the output flag on the same edge. The strobe to the printer is high for exactly the one clock cycle that follows, with the new character on the output.
- R7: After a write, the output flag returns to 1 only after the Idle line has been seen low and then high again. Idle that stays high does not set it.
- R8: Bus select asserts only for a read or write to the base address plus 0, 1 or 2. Accesses to any other address return 0 on read data and change no register or flag.
- R9: Writes to offsets 0 and 2 have no effect. A read at offset 1 returns 0 and changes no flag.
- R10: A read at offset 2 returns the input flag in bit 0, the output flag in bit 1, and 0 in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Processor bus address |
| bus_rd | input | 1 | Processor read request for this cycle |
| bus_wr | input | 1 | Processor write request for this cycle |
| bus_wdata | input | DATA_W | Processor write data |
| bus_rdata | output | DATA_W | Read data, valid while bus_rd is high |
| bus_sel | output | 1 | High when an access hits one of the three registers |
| kbd_valid | input | 1 | Input device Valid level, asynchronous |
| kbd_code | input | DATA_W | Input device code, stable while Valid rises |
| prn_idle | input | 1 | Printer ready for another character |
| prn_char | output | DATA_W | Character presented to the printer |
| prn_stb | output | 1 | One-cycle strobe marking a new character |

## Verification
The bench places a processor read of the input register on the very edge where a new Valid edge lands. A design that lets the clear win there loses the key press. It also leaves Idle high after a write, to catch a design that treats the Idle level alone as readiness and reopens the output flag before the printer has taken the character. Holding Valid high and then dropping it exposes designs that capture on levels or on falling edges. Accesses just outside the window and to the wrong offsets catch a decoder that matches too widely or a write path that ignores the offset.

// File: rtl/pario_pkg.sv
package pario_pkg;

    // register offsets inside the decoded window
    localparam int unsigned REG_COUNT     = 3;
    localparam int unsigned OFF_DIN       = 0;
    localparam int unsigned OFF_DOUT      = 1;
    localparam int unsigned OFF_STAT      = 2;

    // status register bit positions
    localparam int unsigned STAT_SIN_BIT  = 0;
    localparam int unsigned STAT_SOUT_BIT = 1;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_DIN,
        SEL_DOUT,
        SEL_STAT
    } reg_sel_e;

    typedef enum logic {
        IN_EMPTY,
        IN_FULL
    } in_state_e;

    typedef enum logic [1:0] {
        OUT_READY,
        OUT_LOAD,
        OUT_WAIT_ACK,
        OUT_BUSY
    } out_state_e;

endpackage

// File: rtl/pario_addr_dec.sv
module pario_addr_dec
    import pario_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 8'h40
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);

    logic [ADDR_W-1:0] offset;

    assign offset = addr_i - BASE_ADDR;

    always_comb begin
        sel_o = SEL_NONE;
        if (offset == ADDR_W'(OFF_DIN)) begin
            sel_o = SEL_DIN;
        end else if (offset == ADDR_W'(OFF_DOUT)) begin
            sel_o = SEL_DOUT;
        end else if (offset == ADDR_W'(OFF_STAT)) begin
            sel_o = SEL_STAT;
        end
    end

endmodule

// File: rtl/pario_in_chan.sv
module pario_in_chan
    import pario_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_valid_i,
    input  logic [DATA_W-1:0] dev_code_i,
    input  logic              rd_take_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              rise_o
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise;
    logic [DATA_W-1:0]      data_q;
    in_state_e              state_q;
    in_state_e              state_d;

    // synchronizer chain for the asynchronous Valid level
    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= dev_valid_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    assign rise = sync_q[LAST] & ~prev_q;

    // data register: loads only on a detected rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    data_q <= '0;
        else if (rise) data_q <= dev_code_i;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IN_EMPTY;
        else        state_q <= state_d;
    end

    // next state: a new edge wins over a clearing read
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IN_EMPTY: if (rise)                   state_d = IN_FULL;
            IN_FULL:  if (!rise && rd_take_i)     state_d = IN_EMPTY;
            default:                              state_d = IN_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        full_o = (state_q == IN_FULL);
        data_o = data_q;
        rise_o = rise;
    end

endmodule

// File: rtl/pario_out_chan.sv
module pario_out_chan
    import pario_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_load_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              dev_idle_i,
    output logic [DATA_W-1:0] char_o,
    output logic              stb_o,
    output logic              room_o
);

    logic [DATA_W-1:0] char_q;
    out_state_e        state_q;
    out_state_e        state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         char_q <= '0;
        else if (wr_load_i) char_q <= wdata_i;
    end

    // state register; reset state mirrors the device level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OUT_BUSY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr_load_i) begin
            state_d = OUT_LOAD;
        end else begin
            unique case (state_q)
                OUT_READY:    if (!dev_idle_i) state_d = OUT_BUSY;
                OUT_LOAD:                      state_d = OUT_WAIT_ACK;
                OUT_WAIT_ACK: if (!dev_idle_i) state_d = OUT_BUSY;
                OUT_BUSY:     if (dev_idle_i)  state_d = OUT_READY;
                default:                       state_d = OUT_BUSY;
            endcase
        end
    end

    always_comb begin
        char_o = char_q;
        stb_o  = (state_q == OUT_LOAD);
        room_o = (state_q == OUT_READY) || ((state_q == OUT_BUSY) && dev_idle_i);
    end

endmodule

// File: rtl/pario_flag_port.sv
module pario_flag_port
    import pario_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 8,
    parameter int unsigned        DATA_W    = 8,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_sel,
    input  logic              kbd_valid,
    input  logic [DATA_W-1:0] kbd_code,
    input  logic              prn_idle,
    output logic [DATA_W-1:0] prn_char,
    output logic              prn_stb
);

    reg_sel_e          reg_sel;
    logic              rd_take;
    logic              wr_load;
    logic [DATA_W-1:0] din_data;
    logic              sin_flag;
    logic              sout_flag;
    logic              in_rise;
    logic [DATA_W-1:0] status_word;

    pario_addr_dec #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) dec_i (
        .addr_i (bus_addr),
        .sel_o  (reg_sel)
    );

    assign rd_take = bus_rd && (reg_sel == SEL_DIN);
    assign wr_load = bus_wr && (reg_sel == SEL_DOUT);

    pario_in_chan #(
        .DATA_W      (DATA_W),
        .SYNC_STAGES (2)
    ) in_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_valid_i (kbd_valid),
        .dev_code_i  (kbd_code),
        .rd_take_i   (rd_take),
        .data_o      (din_data),
        .full_o      (sin_flag),
        .rise_o      (in_rise)
    );

    pario_out_chan #(
        .DATA_W (DATA_W)
    ) out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_load_i  (wr_load),
        .wdata_i    (bus_wdata),
        .dev_idle_i (prn_idle),
        .char_o     (prn_char),
        .stb_o      (prn_stb),
        .room_o     (sout_flag)
    );

    always_comb begin
        status_word                = '0;
        status_word[STAT_SIN_BIT]  = sin_flag;
        status_word[STAT_SOUT_BIT] = sout_flag;
    end

    // read data mux
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (reg_sel)
                SEL_DIN:  bus_rdata = din_data;
                SEL_STAT: bus_rdata = status_word;
                SEL_DOUT: bus_rdata = '0;
                SEL_NONE: bus_rdata = '0;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign bus_sel = (reg_sel != SEL_NONE) && (bus_rd || bus_wr);

endmodule

// File: rtl/pario_flag_port_chk.sv
module pario_flag_port_chk #(
    parameter int unsigned        ADDR_W    = 8,
    parameter int unsigned        DATA_W    = 8,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 8'h40
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_sel,
    input logic [DATA_W-1:0] prn_char,
    input logic              prn_stb,
    input logic              sin_flag,
    input logic              sout_flag,
    input logic              in_rise
);

    localparam logic [ADDR_W-1:0] A_DIN  = BASE_ADDR;
    localparam logic [ADDR_W-1:0] A_DOUT = BASE_ADDR + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_STAT = BASE_ADDR + ADDR_W'(2);

    logic [ADDR_W-1:0] rel;
    logic              in_window;
    assign rel       = bus_addr - BASE_ADDR;
    assign in_window = (rel < ADDR_W'(3));

    // R6
    strobe_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DOUT) |=> (prn_stb && prn_char == $past(bus_wdata)));

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prn_stb && !(bus_wr && bus_addr == A_DOUT)) |=> !prn_stb);

    // R7
    sout_low_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prn_stb |-> !sout_flag);

    // R4
    sin_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_DIN && !in_rise) |=> !sin_flag);

    // R5
    sin_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_DIN && in_rise) |=> sin_flag);

    // R8
    decode_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_window |-> (!bus_sel && bus_rdata == '0));

    // R10
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_STAT) |-> (bus_rdata == DATA_W'({sout_flag, sin_flag})));

endmodule

bind pario_flag_port pario_flag_port_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE_ADDR (BASE_ADDR)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_sel   (bus_sel),
    .prn_char  (prn_char),
    .prn_stb   (prn_stb),
    .sin_flag  (sin_flag),
    .sout_flag (sout_flag),
    .in_rise   (in_rise)
);

// File: tb/pario_flag_port_tb_top.sv
module pario_flag_port_tb_top;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 8;
    localparam logic [7:0]  BASE   = 8'h40;

    logic              clk;
    logic              rst_n;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_rd;
    logic              bus_wr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata;
    logic              bus_sel;
    logic              kbd_valid;
    logic [DATA_W-1:0] kbd_code;
    logic              prn_idle;
    logic [DATA_W-1:0] prn_char;
    logic              prn_stb;

    logic prn_auto;
    logic auto_idle;
    logic man_idle;
    int   prn_cnt;
    int   n_checks;
    int   n_fails;
    logic done;

    assign prn_idle = prn_auto ? auto_idle : man_idle;

    pario_flag_port #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BASE_ADDR (BASE)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_sel   (bus_sel),
        .kbd_valid (kbd_valid),
        .kbd_code  (kbd_code),
        .prn_idle  (prn_idle),
        .prn_char  (prn_char),
        .prn_stb   (prn_stb)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // printer model: goes busy on a strobe, idle again four cycles later
    initial begin
        auto_idle = 1'b1;
        prn_cnt   = 0;
        forever begin
            @(negedge clk);
            if (prn_auto) begin
                if (prn_stb) begin
                    auto_idle = 1'b0;
                    prn_cnt   = 4;
                end else if (prn_cnt > 0) begin
                    prn_cnt = prn_cnt - 1;
                    if (prn_cnt == 0) auto_idle = 1'b1;
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [7:0] addr, output logic [7:0] data, output logic sel);
        bus_addr = addr;
        bus_rd   = 1'b1;
        #1;
        data = bus_rdata;
        sel  = bus_sel;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] addr, input logic [7:0] data);
        bus_addr  = addr;
        bus_wdata = data;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        logic       s;
        man_idle = 1'b1;
        bus_read(BASE + 8'd2, d, s);
        check("R1 status in reset, idle high", {24'd0, d}, 32'h2);
        man_idle = 1'b0;
        bus_read(BASE + 8'd2, d, s);
        check("R1 status in reset, idle low", {24'd0, d}, 32'h0);
        bus_read(BASE, d, s);
        check("R1 input data reset", {24'd0, d}, 32'h0);
        check("R1 strobe low", {31'd0, prn_stb}, 32'd0);
        check("R1 output char reset", {24'd0, prn_char}, 32'h0);
        man_idle = 1'b1;
    endtask

    task automatic t_capture();
        logic [7:0] d;
        logic       s;
        kbd_code  = 8'hA5;
        kbd_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_read(BASE + 8'd2, d, s);
        check("R2 flag not set before third edge", {31'd0, d[0]}, 32'd0);
        bus_read(BASE + 8'd2, d, s);
        check("R2 flag set after sync", {31'd0, d[0]}, 32'd1);
        bus_read(BASE, d, s);
        check("R4 read returns captured code", {24'd0, d}, 32'hA5);
        bus_read(BASE + 8'd2, d, s);
        check("R4 read clears input flag", {31'd0, d[0]}, 32'd0);
        repeat (6) @(negedge clk);
        bus_read(BASE + 8'd2, d, s);
        check("R3 held Valid does not set flag again", {31'd0, d[0]}, 32'd0);
        kbd_valid = 1'b0;
        kbd_code  = 8'h3C;
        repeat (5) @(negedge clk);
        bus_read(BASE, d, s);
        check("R3 falling Valid does not capture", {24'd0, d}, 32'hA5);
    endtask

    task automatic t_same_cycle();
        logic [7:0] d;
        logic       s;
        kbd_code  = 8'h5A;
        kbd_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_read(BASE, d, s);
        check("R5 colliding read returns old code", {24'd0, d}, 32'hA5);
        bus_read(BASE + 8'd2, d, s);
        check("R5 flag kept after collision", {31'd0, d[0]}, 32'd1);
        bus_read(BASE, d, s);
        check("R5 new code stored", {24'd0, d}, 32'h5A);
        kbd_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_write();
        logic [7:0] d;
        logic       s;
        bus_read(BASE + 8'd2, d, s);
        check("R7 output flag ready before write", {31'd0, d[1]}, 32'd1);
        bus_write(BASE + 8'd1, 8'hC3);
        check("R6 strobe after write", {31'd0, prn_stb}, 32'd1);
        check("R6 char on output", {24'd0, prn_char}, 32'hC3);
        bus_read(BASE + 8'd2, d, s);
        check("R6 write clears output flag", {31'd0, d[1]}, 32'd0);
        check("R6 strobe lasts one cycle", {31'd0, prn_stb}, 32'd0);
        repeat (10) @(negedge clk);
        bus_read(BASE + 8'd2, d, s);
        check("R7 flag back after printer cycle", {31'd0, d[1]}, 32'd1);
    endtask

    task automatic t_handshake();
        logic [7:0] d;
        logic       s;
        man_idle = 1'b1;
        prn_auto = 1'b0;
        bus_write(BASE + 8'd1, 8'h7E);
        repeat (6) @(negedge clk);
        bus_read(BASE + 8'd2, d, s);
        check("R7 steady Idle does not set flag", {31'd0, d[1]}, 32'd0);
        man_idle = 1'b0;
        repeat (3) @(negedge clk);
        bus_read(BASE + 8'd2, d, s);
        check("R7 flag low while busy", {31'd0, d[1]}, 32'd0);
        man_idle = 1'b1;
        repeat (2) @(negedge clk);
        bus_read(BASE + 8'd2, d, s);
        check("R7 flag set after low-high Idle", {31'd0, d[1]}, 32'd1);
        prn_auto = 1'b1;
    endtask

    task automatic t_decode();
        logic [7:0] d;
        logic       s;
        bus_read(BASE + 8'd3, d, s);
        check("R8 read above window data", {24'd0, d}, 32'h0);
        check("R8 read above window select", {31'd0, s}, 32'd0);
        bus_write(BASE + 8'd3, 8'h11);
        check("R8 write above window no strobe", {31'd0, prn_stb}, 32'd0);
        bus_write(BASE - 8'd1, 8'h22);
        check("R8 write below window no strobe", {31'd0, prn_stb}, 32'd0);
        check("R8 char unchanged", {24'd0, prn_char}, 32'h7E);
        bus_read(BASE + 8'd2, d, s);
        check("R8 select inside window", {31'd0, s}, 32'd1);
        check("R8 output flag untouched", {31'd0, d[1]}, 32'd1);
    endtask

    task automatic t_ignored();
        logic [7:0] d;
        logic       s;
        bus_write(BASE, 8'hFF);
        bus_write(BASE + 8'd2, 8'hFF);
        check("R9 status write no strobe", {31'd0, prn_stb}, 32'd0);
        bus_read(BASE, d, s);
        check("R9 input data not writable", {24'd0, d}, 32'h5A);
        kbd_code  = 8'h99;
        kbd_valid = 1'b1;
        repeat (4) @(negedge clk);
        kbd_valid = 1'b0;
        bus_read(BASE + 8'd1, d, s);
        check("R9 output register reads zero", {24'd0, d}, 32'h0);
        bus_read(BASE + 8'd2, d, s);
        check("R10 both flags set", {24'd0, d}, 32'h3);
        bus_read(BASE, d, s);
        check("R10 new code read", {24'd0, d}, 32'h99);
        bus_read(BASE + 8'd2, d, s);
        check("R10 status after clear", {24'd0, d}, 32'h2);
    endtask

    initial begin
        n_checks  = 0;
        n_fails   = 0;
        done      = 1'b0;
        rst_n     = 1'b0;
        bus_addr  = '0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_wdata = '0;
        kbd_valid = 1'b0;
        kbd_code  = '0;
        man_idle  = 1'b1;
        prn_auto  = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n    = 1'b1;
        prn_auto = 1'b1;
        repeat (2) @(negedge clk);
        t_capture();
        t_same_cycle();
        t_write();
        t_handshake();
        t_decode();
        t_ignored();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule